// File: doc/BRIEF.md
# Slotted Delay-Line Contention Scheduler

This block is the electronic scheduler for the output contention stage of a slot-synchronous optical packet switch. Time is divided into packet slots, and a slot is one 72-byte packet at 10 Gb/s, or 57.6 ns. The `slot_tick` strobe marks a slot boundary. In a tick cycle each of `N_IN` inputs may present one request, tagged with a destination output. The scheduler gives every request either a grant or a drop. A grant comes with a delay of 0 to `B` whole slots, which selects a fixed line of a feed-forward delay bank. The delay is chosen so that no two packets leave toward the same output in the same slot.

Each output keeps a reservation calendar of `B+1` bits. Bit d is set when the slot d slots ahead is already taken. The calendar moves forward by one position on every tick. Inputs are served in rotating priority order, so each winner takes the smallest free delay for its destination. A request that finds all `B+1` positions taken is dropped. With `B = 0` the block does plain contention with drop. The block holds no packet storage.

The request side is a valid-only stream and the block never applies back-pressure. A valid request is consumed in the tick cycle that presents it, and its grant or drop appears combinationally in that same cycle. Requests presented outside tick cycles are ignored.

Running totals of grants, of drops and of grants at each delay value let the surrounding logic measure throughput.

Top module: `delay_slot_scheduler`

## Requirements
- R1: After reset every calendar is empty, the rotating pointer is at input 0 and all counters read zero. A first slot whose requests all target distinct outputs grants them all with delay 0.
- R2: In a tick cycle every input with `req_valid` set gets exactly one of `grant` or `drop`, in the same cycle. Inputs without a request get neither.
- R3: A granted request gets the smallest delay d (0 to B) whose calendar bit is clear for its destination, after the inputs served earlier in the same slot have taken theirs. The delay for input i is the binary value in `grant_delay[i*LW +: LW]`, where LW = ceil(log2(B+1)), with a minimum of 1.
- R4: No two granted packets leave toward the same output in the same slot, whether they were granted in the same tick or in different ticks. A packet granted in tick t with delay d leaves in slot t+d.
- R5: Inputs are served in the order p, p+1, … wrapping modulo N_IN. Here p is one past the highest-order input granted in the previous tick. If that tick granted nothing, p is unchanged.
- R6: A request whose destination has all delays 0 to B reserved is dropped.
- R7: The calendars, pointer and counters change only on tick cycles. A cycle without a tick shows no grant and no drop, even when `req_valid` is set.
- R8: With B = 0, each output requested in a tick gets exactly one grant, with delay 0. Every other request to that output is dropped.
- R9: On each tick, `cnt_grant` grows by the number of grants, `cnt_drop` grows by the number of drops, and field d of `cnt_delay` (bits `[d*CW +: CW]`) grows by the number of grants with delay d. All three wrap modulo 2^CW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | Marks the slot-boundary cycle in which requests are resolved |
| req_valid | input | N_IN | One request flag per input |
| req_dest | input | N_IN*DW | Destination output of input i at bits [i*DW +: DW], DW = log2(N_OUT) |
| grant | output | N_IN | Request of input i accepted |
| grant_delay | output | N_IN*LW | Delay-line selection in slots for input i |
| drop | output | N_IN | Request of input i discarded |
| cnt_grant | output | CW | Total granted packets |
| cnt_drop | output | CW | Total dropped packets |
| cnt_delay | output | (B+1)*CW | Grant totals per delay value |

## Verification
The bench builds the main instance with eight inputs, four outputs and a bank depth of two. With that shape, a single slot can hold more requests for one output than it has delay positions, so drops, the use of delays 1 and 2, and the wrap of the rotating pointer all occur within a few slots. A second instance with depth zero shares the same stimulus and exposes the pure contention-with-drop case. The reference model books absolute departure slots instead of a shifting bitmap. It is driven through directed slots that saturate a single output, through idle cycles with requests held high, and through several hundred random slots.

// File: rtl/dss_pkg.sv
package dss_pkg;
  // Width of a delay selection able to encode 0..depth (never less than 1).
  function automatic int unsigned dly_bits(int unsigned depth);
    return (depth > 0) ? $clog2(depth + 1) : 1;
  endfunction
endpackage

// File: rtl/dss_alloc.sv
// Single-pass rotating-priority allocation of delay positions.
module dss_alloc #(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned N_OUT = 16,
  parameter int unsigned B     = 4,
  parameter int unsigned DW    = 4,
  parameter int unsigned LW    = 3,
  parameter int unsigned PW    = 4
) (
  input  logic                       slot_tick,
  input  logic [N_IN-1:0]            req_valid,
  input  logic [N_IN*DW-1:0]         req_dest,
  input  logic [N_OUT-1:0][B:0]      occ,
  input  logic [PW-1:0]              ptr,
  output logic [N_IN-1:0]            grant,
  output logic [N_IN-1:0]            drop,
  output logic [N_IN*LW-1:0]         dly,
  output logic [N_OUT-1:0][B:0]      occ_nxt,
  output logic                       any_gnt,
  output logic [PW-1:0]              last_idx
);
  logic [N_OUT-1:0][B:0] work;

  always_comb begin
    work     = occ;
    grant    = '0;
    drop     = '0;
    dly      = '0;
    any_gnt  = 1'b0;
    last_idx = ptr;
    for (int k = 0; k < N_IN; k++) begin
      int          idx;
      logic [DW-1:0] dst;
      logic        hit;
      idx = (int'(ptr) + k) % N_IN;
      dst = req_dest[idx*DW +: DW];
      hit = 1'b0;
      if (slot_tick && req_valid[idx]) begin
        for (int d = 0; d <= int'(B); d++) begin
          if (!hit && !work[dst][d]) begin
            hit = 1'b1;
            work[dst][d] = 1'b1;
            dly[idx*LW +: LW] = LW'(d);
          end
        end
        if (hit) begin
          grant[idx] = 1'b1;
          any_gnt    = 1'b1;
          last_idx   = PW'(idx);
        end else begin
          drop[idx]  = 1'b1;
        end
      end
    end
    occ_nxt = work;
  end
endmodule

// File: rtl/dss_calendar.sv
// Per-output reservation bitmaps; advance one slot per tick.
module dss_calendar #(
  parameter int unsigned N_OUT = 16,
  parameter int unsigned B     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_tick,
  input  logic [N_OUT-1:0][B:0] occ_nxt,
  output logic [N_OUT-1:0][B:0] occ
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [B:0] row;
    always_ff @(posedge clk) begin
      if (!rst_n)         row <= '0;
      else if (slot_tick) row <= occ_nxt[o] >> 1;
    end
    assign occ[o] = row;
  end
endmodule

// File: rtl/dss_counters.sv
// Grant, drop and per-delay totals.
module dss_counters #(
  parameter int unsigned N_IN = 16,
  parameter int unsigned B    = 4,
  parameter int unsigned LW   = 3,
  parameter int unsigned CW   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_tick,
  input  logic [N_IN-1:0]       grant,
  input  logic [N_IN-1:0]       drop,
  input  logic [N_IN*LW-1:0]    dly,
  output logic [CW-1:0]         cnt_grant,
  output logic [CW-1:0]         cnt_drop,
  output logic [(B+1)*CW-1:0]   cnt_delay
);
  logic [CW-1:0] n_g, n_d;

  always_comb begin
    n_g = '0;
    n_d = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (grant[i]) n_g = n_g + CW'(1);
      if (drop[i])  n_d = n_d + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_grant <= '0;
      cnt_drop  <= '0;
    end else if (slot_tick) begin
      cnt_grant <= cnt_grant + n_g;
      cnt_drop  <= cnt_drop + n_d;
    end
  end

  for (genvar d = 0; d <= B; d++) begin : g_dc
    logic [CW-1:0] cnt, inc;
    always_comb begin
      inc = '0;
      for (int i = 0; i < N_IN; i++)
        if (grant[i] && dly[i*LW +: LW] == LW'(d)) inc = inc + CW'(1);
    end
    always_ff @(posedge clk) begin
      if (!rst_n)         cnt <= '0;
      else if (slot_tick) cnt <= cnt + inc;
    end
    assign cnt_delay[d*CW +: CW] = cnt;
  end
endmodule

// File: rtl/delay_slot_scheduler.sv
// Slotted delay-line contention scheduler for one output contention stage.
module delay_slot_scheduler #(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned N_OUT = 16,   // power of two, at least 2
  parameter int unsigned B     = 4,    // delay bank depth, 0..4 slots
  parameter int unsigned CW    = 32,
  localparam int unsigned DW   = $clog2(N_OUT),
  localparam int unsigned LW   = dss_pkg::dly_bits(B)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_tick,
  input  logic [N_IN-1:0]      req_valid,
  input  logic [N_IN*DW-1:0]   req_dest,
  output logic [N_IN-1:0]      grant,
  output logic [N_IN*LW-1:0]   grant_delay,
  output logic [N_IN-1:0]      drop,
  output logic [CW-1:0]        cnt_grant,
  output logic [CW-1:0]        cnt_drop,
  output logic [(B+1)*CW-1:0]  cnt_delay
);
  localparam int unsigned PW = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic [N_OUT-1:0][B:0] occ, occ_nxt;
  logic [PW-1:0]         ptr, last_idx;
  logic                  any_gnt;

  dss_alloc #(.N_IN(N_IN), .N_OUT(N_OUT), .B(B), .DW(DW), .LW(LW), .PW(PW)) u_alloc (
    .slot_tick (slot_tick),
    .req_valid (req_valid),
    .req_dest  (req_dest),
    .occ       (occ),
    .ptr       (ptr),
    .grant     (grant),
    .drop      (drop),
    .dly       (grant_delay),
    .occ_nxt   (occ_nxt),
    .any_gnt   (any_gnt),
    .last_idx  (last_idx)
  );

  dss_calendar #(.N_OUT(N_OUT), .B(B)) u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_tick (slot_tick),
    .occ_nxt   (occ_nxt),
    .occ       (occ)
  );

  // Rotating priority: next slot starts one past the last winner.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (slot_tick && any_gnt) begin
      if (last_idx == PW'(N_IN - 1)) ptr <= '0;
      else                           ptr <= last_idx + PW'(1);
    end
  end

  dss_counters #(.N_IN(N_IN), .B(B), .LW(LW), .CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_tick (slot_tick),
    .grant     (grant),
    .drop      (drop),
    .dly       (grant_delay),
    .cnt_grant (cnt_grant),
    .cnt_drop  (cnt_drop),
    .cnt_delay (cnt_delay)
  );
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned N_OUT = 16,
  parameter int unsigned B     = 4,
  parameter int unsigned CW    = 32,
  localparam int unsigned DW   = $clog2(N_OUT),
  localparam int unsigned LW   = dss_pkg::dly_bits(B)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                slot_tick,
  input logic [N_IN-1:0]     req_valid,
  input logic [N_IN*DW-1:0]  req_dest,
  input logic [N_IN-1:0]     grant,
  input logic [N_IN*LW-1:0]  grant_delay,
  input logic [N_IN-1:0]     drop,
  input logic [CW-1:0]       cnt_grant,
  input logic [CW-1:0]       cnt_drop
);
  AST_RESOLVE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |-> ((grant | drop) == req_valid)) else $error("resolve");  // R2

  AST_GRANT_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & drop) == '0) else $error("excl");  // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |-> (grant == '0 && drop == '0)) else $error("idle");  // R7

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> ($stable(cnt_grant) && $stable(cnt_drop))) else $error("hold");  // R7

  AST_CNT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> ((cnt_grant - $past(cnt_grant)) == CW'($countones($past(grant)))))
    else $error("cntg");  // R9

  AST_CNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> ((cnt_drop - $past(cnt_drop)) == CW'($countones($past(drop)))))
    else $error("cntd");  // R9

  always @(posedge clk) begin
    if (rst_n && slot_tick) begin
      for (int i = 0; i < N_IN; i++) begin
        if (grant[i]) begin
          AST_DELAY_RANGE: assert (int'(grant_delay[i*LW +: LW]) <= int'(B)) else $error("range");  // R3
        end
        for (int j = i + 1; j < N_IN; j++) begin
          if (grant[i] && grant[j] && req_dest[i*DW +: DW] == req_dest[j*DW +: DW]) begin
            AST_NO_SAME_SLOT: assert (grant_delay[i*LW +: LW] != grant_delay[j*LW +: LW]) else $error("clash");  // R4
          end
        end
      end
    end
  end
endmodule

bind delay_slot_scheduler dss_checker #(.N_IN(N_IN), .N_OUT(N_OUT), .B(B), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_tick   (slot_tick),
  .req_valid   (req_valid),
  .req_dest    (req_dest),
  .grant       (grant),
  .grant_delay (grant_delay),
  .drop        (drop),
  .cnt_grant   (cnt_grant),
  .cnt_drop    (cnt_drop)
);

// File: tb/delay_slot_scheduler_test.sv
module delay_slot_scheduler_test;
  localparam int NI = 8;
  localparam int NO = 4;
  localparam int BD = 2;
  localparam int DW = 2;
  localparam int LW = 2;
  localparam int CW = 16;
  localparam int WIN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_tick = 1'b0;
  logic [NI-1:0] req_valid = '0;
  logic [NI*DW-1:0] req_dest = '0;
  logic [NI-1:0] grant, drop;
  logic [NI*LW-1:0] grant_delay;
  logic [CW-1:0] cnt_grant, cnt_drop;
  logic [(BD+1)*CW-1:0] cnt_delay;
  logic [NI-1:0] nb_grant, nb_drop;
  logic [NI-1:0] nb_delay;
  logic [CW-1:0] nb_cg, nb_cd;
  logic [CW-1:0] nb_cdl;

  always #2 clk = ~clk;  // 250 MHz

  delay_slot_scheduler #(.N_IN(NI), .N_OUT(NO), .B(BD), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .req_valid(req_valid),
    .req_dest(req_dest), .grant(grant), .grant_delay(grant_delay), .drop(drop),
    .cnt_grant(cnt_grant), .cnt_drop(cnt_drop), .cnt_delay(cnt_delay));

  delay_slot_scheduler #(.N_IN(NI), .N_OUT(NO), .B(0), .CW(CW)) uut_nb (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .req_valid(req_valid),
    .req_dest(req_dest), .grant(nb_grant), .grant_delay(nb_delay), .drop(nb_drop),
    .cnt_grant(nb_cg), .cnt_drop(nb_cd), .cnt_delay(nb_cdl));

  typedef struct packed {
    logic [NI-1:0]    g;
    logic [NI-1:0]    dr;
    logic [NI*LW-1:0] dl;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Reference model: absolute departure slots per output.
  bit busy [NO][WIN];
  int tslot = 0, rr = 0;
  int exp_g = 0, exp_dr = 0;
  int exp_dl [BD+1];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic run_slot(input logic [NI-1:0] v, input logic [NI*DW-1:0] dst);
    exp_t e;
    int last;
    bit any;
    e = '0; any = 0; last = 0;
    for (int k = 0; k < NI; k++) begin
      int idx, o;
      bit hit;
      idx = (rr + k) % NI;
      o = int'(dst[idx*DW +: DW]);
      hit = 0;
      if (v[idx]) begin
        for (int d = 0; d <= BD; d++) begin
          if (!hit && !busy[o][(tslot + d) % WIN]) begin
            hit = 1;
            busy[o][(tslot + d) % WIN] = 1;
            e.dl[idx*LW +: LW] = LW'(d);
            exp_dl[d]++;
          end
        end
        if (hit) begin e.g[idx] = 1'b1; last = idx; any = 1; exp_g++; end
        else begin e.dr[idx] = 1'b1; exp_dr++; end
      end
    end
    if (any) rr = (last + 1) % NI;
    for (int o = 0; o < NO; o++) busy[o][tslot % WIN] = 0;
    tslot++;
    exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = v; req_dest = dst; slot_tick = 1'b1;
  endtask

  task automatic idle_cycle(input logic [NI-1:0] v);
    @(posedge clk); #1;
    slot_tick = 1'b0; req_valid = v;
  endtask

  // Monitor / scoreboard
  bit dep [NO][WIN];
  int mslot = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (slot_tick) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected slot", 0, 1);
        end else begin
          e = exp_q.pop_front();
          check(grant == e.g, "R5", "grant vector", grant, e.g);
          check(drop == e.dr, "R6", "drop vector", drop, e.dr);
          for (int i = 0; i < NI; i++)
            if (e.g[i])
              check(grant_delay[i*LW +: LW] == e.dl[i*LW +: LW], "R3", "delay",
                    grant_delay[i*LW +: LW], e.dl[i*LW +: LW]);
        end
        // R4: departure uniqueness from observed grants
        for (int i = 0; i < NI; i++) begin
          if (grant[i]) begin
            int o, s;
            o = int'(req_dest[i*DW +: DW]);
            s = (mslot + int'(grant_delay[i*LW +: LW])) % WIN;
            check(!dep[o][s], "R4", "output booked twice", o, s);
            dep[o][s] = 1;
          end
        end
        for (int o = 0; o < NO; o++) dep[o][mslot % WIN] = 0;
        mslot++;
        // R8: depth-zero instance
        check((nb_grant | nb_drop) == req_valid && (nb_grant & nb_drop) == '0,
              "R8", "nb resolve", nb_grant | nb_drop, req_valid);
        check(nb_delay == '0, "R8", "nb delay", nb_delay, 0);
        for (int o = 0; o < NO; o++) begin
          int rq, gc;
          rq = 0; gc = 0;
          for (int i = 0; i < NI; i++)
            if (req_valid[i] && int'(req_dest[i*DW +: DW]) == o) begin
              rq++;
              if (nb_grant[i]) gc++;
            end
          check(gc == ((rq > 0) ? 1 : 0), "R8", "nb grants per output", gc, (rq > 0) ? 1 : 0);
        end
      end else begin
        check(grant == '0 && drop == '0, "R7", "activity without tick", {grant, drop}, 0);
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d <= BD; d++) exp_dl[d] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(grant == '0 && drop == '0, "R1", "outputs after reset", {grant, drop}, 0);
    check(cnt_grant == '0 && cnt_drop == '0 && cnt_delay == '0, "R1", "counters after reset",
          cnt_grant, 0);
    // R1: distinct destinations on inputs 0..3 -> all delay 0
    run_slot(8'b0000_1111, 16'h00E4);
    // R3/R6: eight requests to output 0, then again
    run_slot(8'hFF, 16'h0000);
    run_slot(8'hFF, 16'h0000);
    // R7: requests held high with no tick
    idle_cycle(8'hFF);
    idle_cycle(8'hFF);
    idle_cycle(8'hFF);
    // R5: sparse requests move the pointer
    run_slot(8'b0100_0100, 16'h5555);
    run_slot(8'b1000_0001, 16'h5555);
    run_slot(8'b0000_0000, 16'h0000);
    run_slot(8'b1111_1111, 16'h5555);
    // Random traffic with occasional idle cycles
    for (int n = 0; n < 400; n++) begin
      logic [NI-1:0] v;
      logic [NI*DW-1:0] dd;
      v = NI'($urandom);
      dd = (NI*DW)'($urandom);
      if (n % 50 < 10) dd = '0;  // hot-spot bursts
      run_slot(v, dd);
      if ($urandom % 4 == 0) idle_cycle(NI'($urandom));
    end
    idle_cycle('0);
    idle_cycle('0);
    @(negedge clk);
    // R9: totals
    check(cnt_grant == CW'(exp_g), "R9", "grant total", cnt_grant, exp_g);
    check(cnt_drop == CW'(exp_dr), "R9", "drop total", cnt_drop, exp_dr);
    for (int d = 0; d <= BD; d++)
      check(cnt_delay[d*CW +: CW] == CW'(exp_dl[d]), "R9", "per-delay total",
            cnt_delay[d*CW +: CW], exp_dl[d]);
    check(exp_q.size() == 0, "R2", "unconsumed expectations", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule